// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a small mixed-signal chip through its operating modes: held in reset, idle in low-power standby, an internal start-up wait, a boost soft-start window and full operation. It takes the external reset pin, the power-on reset flag, two control bits from the register file (run/standby and boost enable), a thermal-shutdown flag, a default-mode strap pin and a one-millisecond tick. From these it produces enables for the internal analog blocks and for the boost converter, a flag that keeps the boost in pulse-frequency soft-start, a signal that forces every LED driver off, and a reset for the register file.

Both delay windows (start-up settling and boost soft-start) last `DLY_MS` ticks, 10 by default. A thermal event sends the chip back to the start-up wait until it clears. Turning boost enable on again while running re-enters soft-start, and the LEDs go dark for that window. The default-mode pin lets a board with no serial host run the chip by forcing the run bit and the audio-sync enable on.

Top module: `power_mode_seq`

## Requirements
- R1: While the reset pin is low or power-on reset is high, the next clock edge puts the machine in the reset state (state_o = 0). reg_rst_o is high only in that state, and all enables are low there.
- R2: When the reset request is released, the machine moves to standby (state_o = 1) on the next edge. It stays there while the effective run bit is low, with core_en_o low and led_off_o high.
- R3: A high default-mode pin makes the effective run bit and sync_en_o 1 whatever the register bits hold. Otherwise sync_en_o follows sync_bit_i.
- R4: In start-up (state_o = 2) the machine counts tick_ms_i pulses. It leaves on the edge that samples the `DLY_MS`-th tick. Cycles with no tick do not advance the count.
- R5: A thermal flag in start-up holds the machine there and restarts the count. A thermal flag in soft-start or normal operation returns it to start-up on the next edge.
- R6: At the end of start-up the machine enters soft-start (state_o = 3) if boost_bit_i is high, and normal (state_o = 4) if it is low.
- R7: In soft-start, boost_en_o, boost_pfm_o and led_off_o are all high. After `DLY_MS` ticks the machine enters normal with boost_en_o high, boost_pfm_o low and led_off_o low.
- R8: In normal, boost_bit_i going low drops boost_en_o on the next edge. Setting it high again re-enters soft-start with the LEDs forced off. boost_bit_i low during soft-start ends it early into normal.
- R9: An effective run bit low in start-up, soft-start or normal gives standby on the next edge. The count is cleared, so the next start-up waits the full delay.
- R10: core_en_o is high in exactly the start-up, soft-start and normal states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer flops |
| rst_pin_ni | input | 1 | External reset pin, active low, synchronous request |
| por_i | input | 1 | Power-on reset active |
| stby_bit_i | input | 1 | Register run bit (0 = standby) |
| boost_bit_i | input | 1 | Register boost enable bit |
| sync_bit_i | input | 1 | Register audio-sync enable bit |
| thermal_i | input | 1 | Thermal shutdown event |
| dflt_mode_i | input | 1 | Default-mode strap pin |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| state_o | output | 3 | Current mode: 0 reset, 1 standby, 2 start-up, 3 soft-start, 4 normal |
| core_en_o | output | 1 | Enable for internal reference and oscillator |
| boost_en_o | output | 1 | Boost converter enable |
| boost_pfm_o | output | 1 | Boost held in pulse-frequency soft-start |
| led_off_o | output | 1 | Force all LED drivers off |
| reg_rst_o | output | 1 | Reset the register file to defaults |
| sync_en_o | output | 1 | Effective audio-sync enable |

## Verification
The bench targets the delay boundary: nine ticks must leave the state alone and the tenth must move it. A counter off by one would leave a cycle early or late. A thermal pulse in the middle of start-up must force a full new wait, and a design that kept the partial count would advance too soon. Boost re-enable from normal must pass through soft-start again with LEDs dark. A design that remembered the earlier soft-start, or that checked only the level of the boost bit, would keep the LEDs lit at full boost with no soft-start. A run-bit drop partway through a delay, followed by a restart, shows whether stale count survives standby.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    PM_RESET = 3'd0,
    PM_STBY  = 3'd1,
    PM_START = 3'd2,
    PM_BSS   = 3'd3,
    PM_NORM  = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pms_delay.sv
module pms_delay #(
  parameter int DLY_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic done_o
);
  localparam int CNT_W = (DLY_MS > 2) ? $clog2(DLY_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = adv_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rst_req_i,
  input  logic      run_i,
  input  logic      thermal_i,
  input  logic      boost_bit_i,
  input  logic      tick_i,
  input  logic      done_i,
  output pm_state_e state_o,
  output logic      boost_on_o,
  output logic      clr_o,
  output logic      adv_o
);
  pm_state_e state_q, state_d;
  logic      boost_on_q, boost_on_d;
  logic      active;

  assign active = (state_q == PM_START) || (state_q == PM_BSS) || (state_q == PM_NORM);
  assign adv_o  = tick_i && !rst_req_i && run_i && !thermal_i &&
                  ((state_q == PM_START) || (state_q == PM_BSS && boost_bit_i));

  always_comb begin
    state_d    = state_q;
    boost_on_d = boost_on_q;
    if (rst_req_i) begin
      state_d = PM_RESET;
    end else if (active && !run_i) begin
      state_d = PM_STBY;
    end else begin
      unique case (state_q)
        PM_RESET: state_d = PM_STBY;
        PM_STBY:  if (run_i) state_d = PM_START;
        PM_START: if (done_i) state_d = boost_bit_i ? PM_BSS : PM_NORM;
        PM_BSS: begin
          if (thermal_i)         state_d = PM_START;
          else if (!boost_bit_i) state_d = PM_NORM;
          else if (done_i) begin
            state_d    = PM_NORM;
            boost_on_d = 1'b1;
          end
        end
        PM_NORM: begin
          if (thermal_i)                      state_d = PM_START;
          else if (boost_bit_i && !boost_on_q) state_d = PM_BSS;
        end
        default: state_d = PM_RESET;
      endcase
    end
    if (state_d != PM_NORM || !boost_bit_i) boost_on_d = 1'b0;
  end

  // thermal in start-up restarts the wait
  assign clr_o = (state_d != state_q) || (state_q == PM_START && thermal_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PM_RESET;
      boost_on_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      boost_on_q <= boost_on_d;
    end
  end

  assign state_o    = state_q;
  assign boost_on_o = boost_on_q;

  // R1
  rst_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> state_q == PM_RESET);
  // R9
  run_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_i && !run_i && active) |=> state_q == PM_STBY);
  // R5
  thermal_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_i && run_i && thermal_i && (state_q == PM_BSS || state_q == PM_NORM))
      |=> state_q == PM_START);
  // R6
  start_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_START && !rst_req_i && run_i && !thermal_i && !boost_bit_i && done_i)
      |=> state_q == PM_NORM);
endmodule

// File: rtl/pms_dec.sv
module pms_dec
  import pms_pkg::*;
(
  input  pm_state_e state_i,
  input  logic      boost_on_i,
  output logic      core_en_o,
  output logic      boost_en_o,
  output logic      boost_pfm_o,
  output logic      led_off_o,
  output logic      reg_rst_o
);
  always_comb begin
    core_en_o   = 1'b0;
    boost_en_o  = 1'b0;
    boost_pfm_o = 1'b0;
    led_off_o   = 1'b1;
    reg_rst_o   = 1'b0;
    unique case (state_i)
      PM_RESET: reg_rst_o = 1'b1;
      PM_STBY:  ;
      PM_START: core_en_o = 1'b1;
      PM_BSS: begin
        core_en_o   = 1'b1;
        boost_en_o  = 1'b1;
        boost_pfm_o = 1'b1;
      end
      PM_NORM: begin
        core_en_o  = 1'b1;
        boost_en_o = boost_on_i;
        led_off_o  = 1'b0;
      end
      default: reg_rst_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/power_mode_seq.sv
module power_mode_seq
  import pms_pkg::*;
#(
  parameter int DLY_MS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_pin_ni,
  input  logic       por_i,
  input  logic       stby_bit_i,
  input  logic       boost_bit_i,
  input  logic       sync_bit_i,
  input  logic       thermal_i,
  input  logic       dflt_mode_i,
  input  logic       tick_ms_i,
  output logic [2:0] state_o,
  output logic       core_en_o,
  output logic       boost_en_o,
  output logic       boost_pfm_o,
  output logic       led_off_o,
  output logic       reg_rst_o,
  output logic       sync_en_o
);
  logic      rst_req, run, clr, adv, done, boost_on;
  pm_state_e state;

  assign rst_req   = !rst_pin_ni || por_i;
  assign run       = stby_bit_i || dflt_mode_i;
  assign sync_en_o = sync_bit_i || dflt_mode_i;

  pms_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_req_i   (rst_req),
    .run_i       (run),
    .thermal_i   (thermal_i),
    .boost_bit_i (boost_bit_i),
    .tick_i      (tick_ms_i),
    .done_i      (done),
    .state_o     (state),
    .boost_on_o  (boost_on),
    .clr_o       (clr),
    .adv_o       (adv)
  );

  pms_delay #(.DLY_MS(DLY_MS)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .done_o (done)
  );

  pms_dec u_dec (
    .state_i     (state),
    .boost_on_i  (boost_on),
    .core_en_o   (core_en_o),
    .boost_en_o  (boost_en_o),
    .boost_pfm_o (boost_pfm_o),
    .led_off_o   (led_off_o),
    .reg_rst_o   (reg_rst_o)
  );

  assign state_o = state;

  // R8
  reenable_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !boost_en_o && boost_bit_i && run && !rst_req && !thermal_i)
      |=> (boost_pfm_o && led_off_o));
endmodule

// File: tb/test_power_mode_seq.sv
module test_power_mode_seq;
  localparam int DLY = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, rst_pin_ni, por_i, stby_bit_i, boost_bit_i, sync_bit_i;
  logic thermal_i, dflt_mode_i, tick_ms_i;
  logic [2:0] state_o;
  logic core_en_o, boost_en_o, boost_pfm_o, led_off_o, reg_rst_o, sync_en_o;

  power_mode_seq #(.DLY_MS(DLY)) i_power_mode_seq (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .por_i(por_i),
    .stby_bit_i(stby_bit_i), .boost_bit_i(boost_bit_i), .sync_bit_i(sync_bit_i),
    .thermal_i(thermal_i), .dflt_mode_i(dflt_mode_i), .tick_ms_i(tick_ms_i),
    .state_o(state_o), .core_en_o(core_en_o), .boost_en_o(boost_en_o),
    .boost_pfm_o(boost_pfm_o), .led_off_o(led_off_o), .reg_rst_o(reg_rst_o),
    .sync_en_o(sync_en_o)
  );

  int n_chk = 0, n_err = 0;
  int m_st = 0, m_cnt = 0;
  bit m_bon = 0;
  bit finished = 0;

  task automatic chk(string tag, string dflt, string nm, int act, int exp);
    string t;
    t = (tag == "") ? dflt : tag;
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", t, nm, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ns = m_st, nc = m_cnt;
    bit nb = m_bon;
    bit rq  = !rst_pin_ni || por_i;
    bit run = stby_bit_i || dflt_mode_i;
    if (rq) ns = 0;
    else case (m_st)
      0: ns = 1;
      1: if (run) ns = 2;
      2: if (!run) ns = 1;
         else if (thermal_i) nc = 0;
         else if (tick_ms_i) begin
           if (m_cnt == DLY-1) ns = boost_bit_i ? 3 : 4; else nc = m_cnt + 1;
         end
      3: if (!run) ns = 1;
         else if (thermal_i) ns = 2;
         else if (!boost_bit_i) ns = 4;
         else if (tick_ms_i) begin
           if (m_cnt == DLY-1) begin ns = 4; nb = 1; end else nc = m_cnt + 1;
         end
      default: if (!run) ns = 1;
         else if (thermal_i) ns = 2;
         else if (boost_bit_i && !m_bon) ns = 3;
    endcase
    if (ns != m_st) nc = 0;
    if (ns != 4 || !boost_bit_i) nb = 0;
    m_st = ns; m_cnt = nc; m_bon = nb;
  endtask

  task automatic compare(string tag);
    chk(tag, "R6",  "state",     int'(state_o),     m_st);
    chk(tag, "R10", "core_en",   int'(core_en_o),   int'(m_st >= 2));
    chk(tag, "R8",  "boost_en",  int'(boost_en_o),  int'(m_st == 3 || (m_st == 4 && m_bon)));
    chk(tag, "R7",  "boost_pfm", int'(boost_pfm_o), int'(m_st == 3));
    chk(tag, "R7",  "led_off",   int'(led_off_o),   int'(m_st != 4));
    chk(tag, "R1",  "reg_rst",   int'(reg_rst_o),   int'(m_st == 0));
    chk(tag, "R3",  "sync_en",   int'(sync_en_o),   int'(sync_bit_i || dflt_mode_i));
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tick_ms_i = 1'b1; step(tag);
      tick_ms_i = 1'b0; step(tag);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c3a_77e1));
    rst_ni = 0; rst_pin_ni = 1; por_i = 0; stby_bit_i = 0; boost_bit_i = 0;
    sync_bit_i = 0; thermal_i = 0; dflt_mode_i = 0; tick_ms_i = 0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_ni = 1;
    step("R2");
    step("R2");
    stby_bit_i = 1; step("R10");
    ticks(DLY-1, "R4");
    repeat (3) step("R4");            // no tick, no advance
    tick_ms_i = 1; step("R6"); tick_ms_i = 0;  // boost low -> normal
    boost_bit_i = 1; step("R8");       // re-enter soft-start
    thermal_i = 1; step("R5"); step("R5");
    ticks(4, "R5");
    thermal_i = 0;
    ticks(DLY, "R6");                  // full fresh wait -> soft-start
    ticks(DLY, "R7");                  // -> normal, boost on
    step("R7");
    boost_bit_i = 0; step("R8");
    boost_bit_i = 1; step("R8");
    ticks(3, "R9");
    stby_bit_i = 0; step("R9");
    stby_bit_i = 1; step("R9");
    ticks(DLY-1, "R9");
    stby_bit_i = 0; dflt_mode_i = 1; step("R3");
    sync_bit_i = 0; step("R3");
    rst_pin_ni = 0; step("R1");
    rst_pin_ni = 1; por_i = 1; step("R1");
    por_i = 0; step("R2");
    for (int i = 0; i < 6000; i++) begin
      tick_ms_i = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 199) == 0) rst_pin_ni = ~rst_pin_ni; else rst_pin_ni = 1'b1;
      por_i = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 59) == 0) stby_bit_i = ~stby_bit_i;
      if ($urandom_range(0, 39) == 0) boost_bit_i = ~boost_bit_i;
      if ($urandom_range(0, 79) == 0) thermal_i = ~thermal_i;
      if ($urandom_range(0, 119) == 0) dflt_mode_i = ~dflt_mode_i;
      if ($urandom_range(0, 29) == 0) sync_bit_i = ~sync_bit_i;
      step("");
    end
    finish_run();
  end
endmodule